// File: doc/BRIEF.md
# Physical Address Range Decoder

This block resolves a physical address against a small table of configured regions. Each region has a base, a size in bytes, an enable and separate read and write permissions. A single access request carries an address, an access width (byte, halfword or word), a kind (instruction fetch, data load or data store) and store data. In the same cycle the block returns the selected region, the offset into it, an exception code and a flag that tells the requester to substitute all ones for the read data. It also asserts a read-forward or write-forward strobe when the region may actually be accessed.

Regions are written one at a time through a configuration port. A write that would make two enabled regions share any byte is refused, the table is left as it was, and an error pulse is raised. The block remembers the region that satisfied the last successful search. It keeps a one-entry log of the most recent access that hit no region, and that log stays until software clears it or a newer fault replaces it.

Top module: `addr_range_decoder`

## Requirements
- R1: An aligned access whose address lies in an enabled region with nonzero size (base <= address < base + size) gives hit_o=1, region_o equal to that region's index and offset_o equal to address minus base, all in the same cycle.
- R2: When the region stored as last used still contains the address, it is selected and mru_hit_o=1. Otherwise the search picks the lowest-numbered region that contains the address, mru_hit_o=0, and that region becomes the last-used region from the next cycle on. The last-used region is unchanged by misaligned accesses and by misses.
- R3: A word access (size 2) with address bits [1:0] nonzero, or a halfword access (size 1) with address bit 0 set, gives exc_o=1 for a fetch or load and exc_o=2 for a store. hit_o, rd_en_o and wr_en_o are then 0, and no fault is logged.
- R4: Byte accesses (size 0) never raise an alignment exception.
- R5: An aligned access that hits no region gives exc_o=3 for an instruction fetch (mode 0) and exc_o=4 for a data load (mode 1) or store (mode 2).
- R6: Every read (mode 0 or 1) that is misaligned or hits no region gives ones_o=1.
- R7: A read that hits a region without read permission gives ones_o=1, rd_en_o=0 and exc_o=0. A read of a readable region gives rd_en_o=1 and ones_o=0.
- R8: A store that hits a region without write permission gives wr_en_o=0, exc_o=0 and ones_o=0. A store to a writable region gives wr_en_o=1.
- R9: From the cycle after a miss (R5), the fault log shows berr_vld_o=1, the access mode, the address, the width as 1, 2 or 4 for size 0, 1 or 2, and the store data for a store or zero otherwise.
- R10: The fault log holds its contents until berr_clr_i is sampled high, which makes berr_vld_o=0 on the next cycle. A new fault replaces the log, and a fault in the same cycle as a clear wins over the clear.
- R11: A configuration write of an enabled region with nonzero size that shares any byte with another enabled, nonzero-size region is refused: the table is unchanged and cfg_err_o is 1 for the next cycle. Touching ranges and rewrites of the same index are accepted, with cfg_err_o=0.
- R12: After reset no region is enabled, there is no last-used region, the fault log is invalid and cfg_err_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Region configuration write strobe |
| cfg_idx_i | input | IDX_W | Region index to write |
| cfg_en_i | input | 1 | Region enable |
| cfg_base_i | input | ADDR_W | Region base address |
| cfg_ext_i | input | ADDR_W | Region size in bytes |
| cfg_rd_i | input | 1 | Region read permission |
| cfg_wr_i | input | 1 | Region write permission |
| cfg_err_o | output | 1 | Previous configuration write was refused for overlap |
| req_vld_i | input | 1 | Access request valid |
| req_addr_i | input | ADDR_W | Access physical address |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| req_mode_i | input | 2 | 0 instruction fetch, 1 data load, 2 data store |
| req_wdata_i | input | DATA_W | Store data |
| berr_clr_i | input | 1 | Clear the fault log |
| hit_o | output | 1 | Access is aligned and inside a region |
| region_o | output | IDX_W | Selected region index |
| offset_o | output | ADDR_W | Address minus region base |
| mru_hit_o | output | 1 | Selected through the last-used region |
| exc_o | output | 3 | 0 none, 1 load alignment, 2 store alignment, 3 fetch bus error, 4 data bus error |
| ones_o | output | 1 | Read data must be replaced by all ones |
| rd_en_o | output | 1 | Read forwarded to the region |
| wr_en_o | output | 1 | Store forwarded to the region |
| berr_vld_o | output | 1 | Fault log valid |
| berr_mode_o | output | 2 | Logged access mode |
| berr_addr_o | output | ADDR_W | Logged address |
| berr_width_o | output | 3 | Logged width in bytes |
| berr_data_o | output | DATA_W | Logged store data |

## Verification
The disjointness check on the match vector takes for granted that the region table can only change through the configuration port, so the overlap guard is the only thing keeping two matches from coexisting. The stimulus writes the table only through that port, including refused and boundary-touching writes. The checks of the fault log and the last-used register assume that the request fields are known whenever req_vld_i is high. The stimulus therefore drives every field on each request and uses only the defined size and mode codes. Configuration and access cycles never overlap, so the table is steady while results are compared.

// File: rtl/ard_pkg.sv
package ard_pkg;
  localparam logic [1:0] SZ_BYTE  = 2'd0;
  localparam logic [1:0] SZ_HALF  = 2'd1;
  localparam logic [1:0] SZ_WORD  = 2'd2;
  localparam logic [1:0] MD_FETCH = 2'd0;
  localparam logic [1:0] MD_LOAD  = 2'd1;
  localparam logic [1:0] MD_STORE = 2'd2;

  typedef enum logic [2:0] {
    EX_NONE = 3'd0,
    EX_ADEL = 3'd1,
    EX_ADES = 3'd2,
    EX_IBE  = 3'd3,
    EX_DBE  = 3'd4
  } exc_e;

  function automatic logic [2:0] width_bytes(input logic [1:0] size);
    case (size)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/ard_region_file.sv
module ard_region_file #(
  parameter int N  = 8,
  parameter int AW = 32,
  parameter int IW = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_we_i,
  input  logic [IW-1:0]         cfg_idx_i,
  input  logic                  cfg_en_i,
  input  logic [AW-1:0]         cfg_base_i,
  input  logic [AW-1:0]         cfg_ext_i,
  input  logic                  cfg_rd_i,
  input  logic                  cfg_wr_i,
  output logic [N-1:0]          en_o,
  output logic [N-1:0][AW-1:0]  base_o,
  output logic [N-1:0][AW-1:0]  ext_o,
  output logic [N-1:0]          rd_ok_o,
  output logic [N-1:0]          wr_ok_o,
  output logic                  cfg_err_o
);
  logic [N-1:0]         en_q, rd_q, wr_q, clash;
  logic [N-1:0][AW-1:0] base_q, ext_q;
  logic                 err_q;
  logic [AW:0]          new_end;
  logic                 idx_ok;

  assign new_end = {1'b0, cfg_base_i} + {1'b0, cfg_ext_i};
  assign idx_ok  = int'(cfg_idx_i) < N;

  // pairwise overlap of the incoming region against every other live one
  for (genvar g = 0; g < N; g++) begin : g_clash
    logic [AW:0] old_end;
    assign old_end  = {1'b0, base_q[g]} + {1'b0, ext_q[g]};
    assign clash[g] = en_q[g] && (cfg_idx_i != IW'(g)) && cfg_en_i &&
                      (ext_q[g] != '0) && (cfg_ext_i != '0) &&
                      ({1'b0, cfg_base_i} < old_end) &&
                      ({1'b0, base_q[g]} < new_end);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      rd_q   <= '0;
      wr_q   <= '0;
      base_q <= '0;
      ext_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= cfg_we_i && (|clash);
      if (cfg_we_i && !(|clash) && idx_ok) begin
        en_q[cfg_idx_i]   <= cfg_en_i;
        rd_q[cfg_idx_i]   <= cfg_rd_i;
        wr_q[cfg_idx_i]   <= cfg_wr_i;
        base_q[cfg_idx_i] <= cfg_base_i;
        ext_q[cfg_idx_i]  <= cfg_ext_i;
      end
    end
  end

  assign en_o      = en_q;
  assign base_o    = base_q;
  assign ext_o     = ext_q;
  assign rd_ok_o   = rd_q;
  assign wr_ok_o   = wr_q;
  assign cfg_err_o = err_q;

  // R11: a refused write leaves the table untouched
  a_r11_reject_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> ($stable(en_q) && $stable(base_q) && $stable(ext_q) &&
                   $stable(rd_q) && $stable(wr_q)));
endmodule

// File: rtl/ard_lookup.sv
module ard_lookup #(
  parameter int N  = 8,
  parameter int AW = 32,
  parameter int IW = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [AW-1:0]         addr_i,
  input  logic                  upd_i,
  input  logic [N-1:0]          en_i,
  input  logic [N-1:0][AW-1:0]  base_i,
  input  logic [N-1:0][AW-1:0]  ext_i,
  output logic [N-1:0]          match_o,
  output logic [IW-1:0]         sel_o,
  output logic [AW-1:0]         off_o,
  output logic                  mru_hit_o
);
  logic [N-1:0]  m;
  logic [IW-1:0] prio, mru_q;
  logic          mru_vld_q, mru_hit;

  for (genvar g = 0; g < N; g++) begin : g_match
    logic [AW-1:0] diff;
    assign diff = addr_i - base_i[g];
    assign m[g] = en_i[g] && (addr_i >= base_i[g]) && (diff < ext_i[g]);
  end

  // lowest index wins: scan downward, last assignment sticks
  always_comb begin
    prio = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (m[i]) prio = IW'(i);
    end
  end

  assign mru_hit = mru_vld_q && m[mru_q];
  assign sel_o   = mru_hit ? mru_q : prio;
  assign off_o   = addr_i - base_i[sel_o];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mru_q     <= '0;
      mru_vld_q <= 1'b0;
    end else if (upd_i && (|m) && !mru_hit) begin
      mru_q     <= prio;
      mru_vld_q <= 1'b1;
    end
  end

  assign match_o   = m;
  assign mru_hit_o = mru_hit;

  // R1: the table never yields two candidate regions
  a_r1_disjoint: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(m));
  // R2: a successful lookup leaves its region as the remembered one
  a_r2_learn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && (|m)) |=> (mru_vld_q && (mru_q == $past(sel_o))));
endmodule

// File: rtl/ard_berr_log.sv
module ard_berr_log #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          err_i,
  input  logic          clr_i,
  input  logic [1:0]    mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  input  logic [DW-1:0] data_i,
  output logic          vld_o,
  output logic [1:0]    mode_o,
  output logic [AW-1:0] addr_o,
  output logic [2:0]    width_o,
  output logic [DW-1:0] data_o
);
  import ard_pkg::*;

  logic          vld_q;
  logic [1:0]    mode_q;
  logic [AW-1:0] addr_q;
  logic [2:0]    width_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      mode_q  <= '0;
      addr_q  <= '0;
      width_q <= '0;
      data_q  <= '0;
    end else if (err_i) begin
      vld_q   <= 1'b1;
      mode_q  <= mode_i;
      addr_q  <= addr_i;
      width_q <= width_bytes(size_i);
      data_q  <= (mode_i == MD_STORE) ? data_i : '0;
    end else if (clr_i) begin
      vld_q <= 1'b0;
    end
  end

  assign vld_o   = vld_q;
  assign mode_o  = mode_q;
  assign addr_o  = addr_q;
  assign width_o = width_q;
  assign data_o  = data_q;

  // R9: a fault is logged on the next cycle
  a_r9_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> (vld_o && (addr_o == $past(addr_i)) && (mode_o == $past(mode_i))));
  // R10: log holds without clear or new fault
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && !err_i && !clr_i) |=> (vld_o && $stable(addr_o) && $stable(data_o) &&
                                     $stable(width_o) && $stable(mode_o)));
  // R10: a bare clear empties the log
  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !err_i) |=> !vld_o);
endmodule

// File: rtl/addr_range_decoder.sv
module addr_range_decoder #(
  parameter  int N_REGIONS = 8,
  parameter  int ADDR_W    = 32,
  parameter  int DATA_W    = 32,
  localparam int IDX_W     = (N_REGIONS > 1) ? $clog2(N_REGIONS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic              cfg_en_i,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic [ADDR_W-1:0] cfg_ext_i,
  input  logic              cfg_rd_i,
  input  logic              cfg_wr_i,
  output logic              cfg_err_o,
  input  logic              req_vld_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_size_i,
  input  logic [1:0]        req_mode_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              berr_clr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  region_o,
  output logic [ADDR_W-1:0] offset_o,
  output logic              mru_hit_o,
  output logic [2:0]        exc_o,
  output logic              ones_o,
  output logic              rd_en_o,
  output logic              wr_en_o,
  output logic              berr_vld_o,
  output logic [1:0]        berr_mode_o,
  output logic [ADDR_W-1:0] berr_addr_o,
  output logic [2:0]        berr_width_o,
  output logic [DATA_W-1:0] berr_data_o
);
  import ard_pkg::*;

  logic [N_REGIONS-1:0]             en, rd_ok, wr_ok, match;
  logic [N_REGIONS-1:0][ADDR_W-1:0] base, ext;
  logic [IDX_W-1:0]                 sel;
  logic [ADDR_W-1:0]                off;
  logic                             lk_mru, misal, is_read, is_store, any_m, hit, miss;
  exc_e                             exc;

  ard_region_file #(.N(N_REGIONS), .AW(ADDR_W), .IW(IDX_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_we_i  (cfg_we_i),
    .cfg_idx_i (cfg_idx_i),
    .cfg_en_i  (cfg_en_i),
    .cfg_base_i(cfg_base_i),
    .cfg_ext_i (cfg_ext_i),
    .cfg_rd_i  (cfg_rd_i),
    .cfg_wr_i  (cfg_wr_i),
    .en_o      (en),
    .base_o    (base),
    .ext_o     (ext),
    .rd_ok_o   (rd_ok),
    .wr_ok_o   (wr_ok),
    .cfg_err_o (cfg_err_o)
  );

  assign is_store = (req_mode_i == MD_STORE);
  assign is_read  = !is_store;
  assign misal    = ((req_size_i == SZ_HALF) && req_addr_i[0]) ||
                    ((req_size_i[1]) && (req_addr_i[1:0] != 2'b00));

  ard_lookup #(.N(N_REGIONS), .AW(ADDR_W), .IW(IDX_W)) u_lookup (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (req_addr_i),
    .upd_i    (req_vld_i && !misal),
    .en_i     (en),
    .base_i   (base),
    .ext_i    (ext),
    .match_o  (match),
    .sel_o    (sel),
    .off_o    (off),
    .mru_hit_o(lk_mru)
  );

  assign any_m = |match;
  assign hit   = req_vld_i && !misal && any_m;
  assign miss  = req_vld_i && !misal && !any_m;

  always_comb begin
    exc = EX_NONE;
    if (req_vld_i) begin
      if (misal)       exc = is_read ? EX_ADEL : EX_ADES;
      else if (!any_m) exc = (req_mode_i == MD_FETCH) ? EX_IBE : EX_DBE;
    end
  end

  assign hit_o     = hit;
  assign region_o  = hit ? sel : '0;
  assign offset_o  = hit ? off : '0;
  assign mru_hit_o = hit && lk_mru;
  assign exc_o     = exc;
  assign rd_en_o   = hit && is_read && rd_ok[sel];
  assign wr_en_o   = hit && is_store && wr_ok[sel];
  assign ones_o    = req_vld_i && is_read && !rd_en_o;

  ard_berr_log #(.AW(ADDR_W), .DW(DATA_W)) u_berr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .err_i  (miss),
    .clr_i  (berr_clr_i),
    .mode_i (req_mode_i),
    .addr_i (req_addr_i),
    .size_i (req_size_i),
    .data_i (req_wdata_i),
    .vld_o  (berr_vld_o),
    .mode_o (berr_mode_o),
    .addr_o (berr_addr_o),
    .width_o(berr_width_o),
    .data_o (berr_data_o)
  );

  // R8: stores reach the region only when clean and hitting
  a_r8_wr_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (is_store && hit_o && (exc_o == 3'd0) && !ones_o));
  // R6: the all-ones override only applies to reads that were not forwarded
  a_r6_ones_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ones_o |-> (is_read && !rd_en_o));
  // R3: alignment faults block every forward
  a_r3_align_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((exc_o == 3'd1) || (exc_o == 3'd2)) |-> (!hit_o && !rd_en_o && !wr_en_o));
  // R2: shortcut selection implies a hit
  a_r2_mru_is_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mru_hit_o |-> hit_o);
  // R5: bus errors reach the log
  a_r5_berr_logged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((exc_o == 3'd3) || (exc_o == 3'd4)) |=> (berr_vld_o && (berr_mode_o == $past(req_mode_i))));
endmodule

// File: tb/sim_addr_range_decoder.sv
`timescale 1ns/1ps
module sim_addr_range_decoder;
  import ard_pkg::*;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        cfg_we_i = 0, cfg_en_i = 0, cfg_rd_i = 0, cfg_wr_i = 0;
  logic [2:0]  cfg_idx_i = '0;
  logic [31:0] cfg_base_i = '0, cfg_ext_i = '0;
  logic        cfg_err_o;
  logic        req_vld_i = 0, berr_clr_i = 0;
  logic [31:0] req_addr_i = '0, req_wdata_i = '0;
  logic [1:0]  req_size_i = '0, req_mode_i = '0;
  logic        hit_o, mru_hit_o, ones_o, rd_en_o, wr_en_o, berr_vld_o;
  logic [2:0]  region_o, exc_o, berr_width_o;
  logic [31:0] offset_o, berr_addr_o, berr_data_o;
  logic [1:0]  berr_mode_o;

  always #2 clk = ~clk;

  addr_range_decoder u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we_i), .cfg_idx_i(cfg_idx_i), .cfg_en_i(cfg_en_i),
    .cfg_base_i(cfg_base_i), .cfg_ext_i(cfg_ext_i), .cfg_rd_i(cfg_rd_i),
    .cfg_wr_i(cfg_wr_i), .cfg_err_o(cfg_err_o),
    .req_vld_i(req_vld_i), .req_addr_i(req_addr_i), .req_size_i(req_size_i),
    .req_mode_i(req_mode_i), .req_wdata_i(req_wdata_i), .berr_clr_i(berr_clr_i),
    .hit_o(hit_o), .region_o(region_o), .offset_o(offset_o), .mru_hit_o(mru_hit_o),
    .exc_o(exc_o), .ones_o(ones_o), .rd_en_o(rd_en_o), .wr_en_o(wr_en_o),
    .berr_vld_o(berr_vld_o), .berr_mode_o(berr_mode_o), .berr_addr_o(berr_addr_o),
    .berr_width_o(berr_width_o), .berr_data_o(berr_data_o)
  );

  typedef struct {
    logic [31:0] addr, data;
    logic [1:0]  size, mode;
    logic        clr, err;
    logic [42:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  int n_chk = 0, n_fail = 0;
  bit done = 0, reported = 0;

  // reference table, maintained from accepted configuration writes
  logic        m_en[8], m_rd[8], m_wr[8];
  logic [31:0] m_base[8], m_ext[8];
  logic        m_mru_vld = 0;
  int          m_mru = 0;
  logic [69:0] exp_rec = '0;

  task automatic chk(input bit ok, input string tag, input logic [127:0] got, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic bit in_r(int i, logic [31:0] a);
    return m_en[i] && (m_ext[i] != 0) && (a >= m_base[i]) && ((a - m_base[i]) < m_ext[i]);
  endfunction

  task automatic cfg(input int idx, input logic en, input logic [31:0] b, e,
                     input logic rd, wr, input logic exp_err);
    @(negedge clk);
    req_vld_i = 0; berr_clr_i = 0;
    cfg_we_i = 1; cfg_idx_i = 3'(idx); cfg_en_i = en; cfg_base_i = b;
    cfg_ext_i = e; cfg_rd_i = rd; cfg_wr_i = wr;
    @(negedge clk);
    cfg_we_i = 0;
    #1;
    chk(cfg_err_o == exp_err, "R11 config status", 128'(cfg_err_o), 128'(exp_err));
    if (!exp_err) begin
      m_en[idx] = en; m_base[idx] = b; m_ext[idx] = e; m_rd[idx] = rd; m_wr[idx] = wr;
    end
  endtask

  task automatic access(input logic [1:0] mode, size, input logic [31:0] addr, data,
                        input logic clr, input string tag);
    item_t it;
    logic mis, rd_acc, hit, mru, ones, rden, wren;
    logic [2:0] exc;
    logic [31:0] off;
    int sel;
    rd_acc = (mode != MD_STORE);
    mis = ((size == SZ_HALF) && addr[0]) || ((size == SZ_WORD) && (addr[1:0] != 0));
    sel = -1; mru = 0; off = 0; rden = 0; wren = 0;
    if (!mis) begin
      if (m_mru_vld && in_r(m_mru, addr)) begin sel = m_mru; mru = 1; end
      else for (int i = 0; i < 8; i++) if (sel < 0 && in_r(i, addr)) sel = i;
    end
    hit = !mis && (sel >= 0);
    if (hit) begin
      off = addr - m_base[sel];
      rden = rd_acc && m_rd[sel];
      wren = !rd_acc && m_wr[sel];
      if (!mru) begin m_mru_vld = 1; m_mru = sel; end
    end
    exc = mis ? (rd_acc ? 3'd1 : 3'd2) : (!hit ? ((mode == MD_FETCH) ? 3'd3 : 3'd4) : 3'd0);
    ones = rd_acc && !rden;
    it.addr = addr; it.data = data; it.size = size; it.mode = mode; it.clr = clr;
    it.err = !mis && !hit; it.tag = tag;
    it.exp = {hit, hit ? 3'(sel) : 3'd0, off, mru, exc, ones, rden, wren};
    @(negedge clk);
    cfg_we_i = 0;
    req_vld_i = 1; req_mode_i = mode; req_size_i = size; req_addr_i = addr;
    req_wdata_i = data; berr_clr_i = clr;
    q.push_back(it);
  endtask

  // monitor: compares the current access result and the fault log
  initial begin
    item_t it;
    logic [42:0] got;
    logic [69:0] rec;
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        got = {hit_o, region_o, offset_o, mru_hit_o, exc_o, ones_o, rd_en_o, wr_en_o};
        chk(got == it.exp, it.tag, 128'(got), 128'(it.exp));
        rec = {berr_vld_o, berr_mode_o, berr_addr_o, berr_width_o, berr_data_o};
        chk(rec == exp_rec, "R9 R10 fault log", 128'(rec), 128'(exp_rec));
        if (it.err)
          exp_rec = {1'b1, it.mode, it.addr, width_bytes(it.size),
                     (it.mode == MD_STORE) ? it.data : 32'd0};
        else if (it.clr)
          exp_rec[69] = 1'b0;
      end
    end
  end

  task automatic finish_run();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_en[i] = 0; m_rd[i] = 0; m_wr[i] = 0; m_base[i] = 0; m_ext[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_ni = 1;
    #1;
    chk({berr_vld_o, cfg_err_o, hit_o, exc_o, ones_o, mru_hit_o} == '0, "R12 reset outputs",
        128'({berr_vld_o, cfg_err_o, hit_o, exc_o, ones_o, mru_hit_o}), 128'(0));
    access(MD_LOAD, SZ_WORD, 32'h1000, 32'hDEAD, 0, "R12 empty table miss");

    cfg(0, 1, 32'h1000, 32'h1000, 1, 1, 0);
    cfg(1, 1, 32'h4000, 32'h0100, 1, 0, 0);
    cfg(2, 1, 32'h8000, 32'h0040, 0, 1, 0);
    cfg(5, 1, 32'h2000, 32'h0800, 1, 1, 0);
    cfg(3, 1, 32'h1800, 32'h0100, 1, 1, 1);
    cfg(3, 1, 32'h2800, 32'h0100, 1, 1, 0);
    cfg(3, 1, 32'h27F0, 32'h0020, 1, 1, 1);
    cfg(0, 1, 32'h1000, 32'h0800, 1, 1, 0);
    cfg(0, 1, 32'h1000, 32'h1000, 1, 1, 0);

    access(MD_LOAD,  SZ_WORD, 32'h1010, 32'h0, 0, "R1 region0 offset");
    access(MD_LOAD,  SZ_WORD, 32'h1FFC, 32'h0, 0, "R2 shortcut last byte");
    access(MD_FETCH, SZ_WORD, 32'h2004, 32'h0, 0, "R1 fetch region5");
    access(MD_LOAD,  SZ_BYTE, 32'h2007, 32'h0, 0, "R2 shortcut region5");
    access(MD_LOAD,  SZ_WORD, 32'h1800, 32'h0, 0, "R11 refused overlap kept region0");
    access(MD_LOAD,  SZ_WORD, 32'h2810, 32'h0, 0, "R1 adjacent region3");
    access(MD_LOAD,  SZ_WORD, 32'h1002, 32'h0, 0, "R3 word load misaligned");
    access(MD_STORE, SZ_HALF, 32'h1001, 32'h77, 0, "R3 half store misaligned");
    access(MD_STORE, SZ_WORD, 32'h1006, 32'h77, 0, "R3 word store misaligned");
    access(MD_LOAD,  SZ_BYTE, 32'h1003, 32'h0, 0, "R4 byte load odd");
    access(MD_STORE, SZ_BYTE, 32'h2801, 32'h11, 0, "R4 byte store odd");
    access(MD_LOAD,  SZ_HALF, 32'h1002, 32'h0, 0, "R3 aligned half");
    access(MD_LOAD,  SZ_WORD, 32'h9001, 32'h0, 0, "R3 misaligned hole not logged");
    access(MD_FETCH, SZ_WORD, 32'h9000, 32'hBEEF, 0, "R5 R6 fetch miss");
    access(MD_LOAD,  SZ_HALF, 32'h3000, 32'hBEEF, 0, "R5 R6 load miss");
    access(MD_STORE, SZ_BYTE, 32'hA000, 32'h5A, 0, "R5 store miss");
    access(MD_LOAD,  SZ_WORD, 32'h4010, 32'h0, 0, "R7 readable region");
    access(MD_STORE, SZ_WORD, 32'h4010, 32'h99, 0, "R8 read only drops store");
    access(MD_LOAD,  SZ_WORD, 32'h8000, 32'h0, 0, "R7 write only read ones");
    access(MD_STORE, SZ_HALF, 32'h8002, 32'h33, 0, "R8 write only store forwarded");
    access(MD_LOAD,  SZ_WORD, 32'h1000, 32'h0, 1, "R10 clear pulse");
    access(MD_LOAD,  SZ_WORD, 32'h1004, 32'h0, 0, "R10 after clear");
    access(MD_FETCH, SZ_WORD, 32'hF000, 32'h0, 1, "R10 fault beats clear");
    access(MD_LOAD,  SZ_WORD, 32'h1008, 32'h0, 0, "R10 fault kept");
    access(MD_LOAD,  SZ_WORD, 32'h100C, 32'h0, 0, "R2 final");
    @(negedge clk);
    req_vld_i = 0; berr_clr_i = 0;
    repeat (3) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule